// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block models the write-side command interface of a parallel NOR flash for buffered programming. It watches bus write cycles, each given as an address, a data word and a one-cycle write strobe. It checks the unlock, setup, word-count, load and confirm ordering, and fills a program buffer that is one page wide. After confirmation it runs a modelled busy period and then merges the buffered words into an internal memory array. Bits can only go from 1 to 0.

A read port is combinational. While a program is running, or after the block has aborted, a read from the bank being programmed returns a status word. A read from the other bank returns array contents. A read/reset command clears an abort. Program-suspend and program-resume commands pause and continue the busy period.

With the defaults, the array is 2048 words of 16 bits. The bank is address bit 10, the page is address bits 10:5, and the buffer holds 32 words. A program takes 8 busy cycles.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset, every array word reads 0xFFFF, and both `busy` and `err` are low.
- R2: A program starts only with this order of write cycles:
  - 0xAA to address 0x555, then 0x55 to address 0x2AA.
  - Setup code 0x25 to any address. Its bank (bit 10) becomes the target bank.
  - A count n to an address in the target bank.
  - n+1 loads of address and data.
  - Confirm code 0x29 to an address in the target bank.
  
  Idle cycles between writes are allowed. The confirm raises `busy` in the next cycle. Command codes are compared on data bits 7:0.
- R3: At the end of the busy period, each loaded word becomes the old array word ANDed with the buffered data. No bit ever changes from 0 to 1.
- R4: Every load decrements the remaining count, including a repeated address. A repeated address programs the data loaded last.
- R5: A count n of 32 or more (n+1 larger than the 32-word buffer) aborts. The status word then has bit 5 set and bit 1 clear.
- R6: The block aborts and leaves the array untouched in each of these cases:
  - a count or first load outside the target bank;
  - a later load outside the page of the first load (address bits 10:5);
  - a confirm-phase write that is not 0x29 to the target bank.
  
  The status word then has bit 1 set and bit 5 clear.
- R7: `busy` stays high for 8 cycles when the first loaded address is a multiple of 32, and for 16 cycles otherwise. Afterwards the block is back in read mode.
- R8: While busy, a read of the target bank returns this status word:
  - bit 7 is the complement of data bit 7 of the last loaded word;
  - bit 6 flips after each cycle with `rd_en` high;
  - all other bits are 0.
  
  A read of the other bank returns array data.
- R9: While aborted, `err` is high. Reads of the target bank return the status word, where bit 7 is the complement of the last loaded bit 7, or 1 if nothing was loaded. Reads of the other bank return array data.
- R10: Writing 0xF0 while aborted clears `err` and returns the block to read mode. Later reads of either bank return array data.
- R11: Writing 0xB0 while busy pauses the program: `busy` drops, the timer holds, and reads return the old array data. Writing 0x30 resumes it. The total number of busy cycles is unchanged.
- R12: A wrong first or second unlock cycle returns the block to read mode. The setup, count, load and confirm writes that follow have no effect: `busy` and `err` stay low and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data or command code |
| rd_en | input | 1 | Read strobe; advances the status toggle bit |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Array word or status word |
| busy | output | 1 | Program in progress (not suspended) |
| err | output | 1 | Aborted; waiting for read/reset |

## Verification
The main function is swept over every word count from 1 to 32. The start offsets alternate between aligned and unaligned, and the pages alternate between the two banks. This separates count handling, page placement and the 8-cycle versus 16-cycle busy length. A second sweep with fresh data over the same pages tells AND-merging apart from plain overwriting. Separate runs cover the following cases:
- a repeated load address;
- a count overflow, an out-of-page load, a wrong confirm code and a count written to the other bank, which separate the two abort flags;
- a suspend and resume in mid-program;
- a broken unlock, which must leave everything untouched.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_SETUP    = 8'h25;
    localparam logic [7:0] CMD_CONFIRM  = 8'h29;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESUME   = 8'h30;

    localparam int unsigned UNLOCK_ADDR_A = 'h555;
    localparam int unsigned UNLOCK_ADDR_B = 'h2AA;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_COUNT,
        S_FIRST,
        S_LOAD,
        S_CONFIRM,
        S_BUSY,
        S_SUSP,
        S_ABORT
    } seq_state_e;

    typedef struct packed {
        logic d7_inv;
        logic toggle;
        logic overflow;
        logic abort;
    } status_t;

    function automatic logic [15:0] pack_status(status_t s);
        logic [15:0] w;
        w    = '0;
        w[7] = s.d7_inv;
        w[6] = s.toggle;
        w[5] = s.overflow;
        w[1] = s.abort;
        return w;
    endfunction

endpackage

// File: rtl/fbp_status.sv
module fbp_status
    import fbp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state_i,
    input  logic          blk_i,
    input  logic          rd_en_i,
    input  logic          rd_bank_i,
    input  logic          d7_inv_i,
    input  logic          ovf_i,
    input  logic          abt_i,
    output logic          show_o,
    output logic [DW-1:0] word_o
);

    logic    tgl;
    status_t st;

    assign show_o = ((state_i == S_BUSY) || (state_i == S_ABORT)) && (rd_bank_i == blk_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl <= 1'b0;
        end else if (rd_en_i && show_o) begin
            tgl <= ~tgl;
        end
    end

    always_comb begin
        st.d7_inv   = d7_inv_i;
        st.toggle   = tgl;
        st.overflow = ovf_i;
        st.abort    = abt_i;
        word_o      = DW'(pack_status(st));
    end

endmodule

// File: rtl/fbp_prog_buf.sv
module fbp_prog_buf #(
    parameter int DW      = 16,
    parameter int PG_BITS = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_i,
    input  logic                        we_i,
    input  logic [PG_BITS-1:0]          idx_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [(1<<PG_BITS)-1:0]     valid_o,
    output logic [(1<<PG_BITS)-1:0][DW-1:0] data_o
);

    localparam int NSLOT = 1 << PG_BITS;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                valid_o[g] <= 1'b0;
                data_o[g]  <= '1;
            end else if (we_i && (idx_i == PG_BITS'(g))) begin
                valid_o[g] <= 1'b1;
                data_o[g]  <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
    parameter int AW      = 11,
    parameter int DW      = 16,
    parameter int PG_BITS = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            commit_i,
    input  logic [AW-PG_BITS-1:0]           page_i,
    input  logic [(1<<PG_BITS)-1:0]         valid_i,
    input  logic [(1<<PG_BITS)-1:0][DW-1:0] data_i,
    input  logic [AW-1:0]                   rd_addr_i,
    output logic [DW-1:0]                   rd_data_o
);

    localparam int DEPTH = 1 << AW;
    localparam int NSLOT = 1 << PG_BITS;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (commit_i) begin
            for (int j = 0; j < NSLOT; j++) begin
                if (valid_i[j]) begin
                    mem[{page_i, PG_BITS'(j)}] <= mem[{page_i, PG_BITS'(j)}] & data_i[j];
                end
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/fbp_seq_fsm.sv
module fbp_seq_fsm
    import fbp_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 16,
    parameter int PG_BITS  = 5,
    parameter int PROG_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    output seq_state_e            state_o,
    output logic                  blk_o,
    output logic [AW-PG_BITS-1:0] page_o,
    output logic                  buf_clr_o,
    output logic                  buf_we_o,
    output logic [PG_BITS-1:0]    buf_idx_o,
    output logic                  commit_o,
    output logic                  d7_inv_o,
    output logic                  ovf_o,
    output logic                  abt_o
);

    localparam int NSLOT = 1 << PG_BITS;
    localparam int CW    = $clog2(NSLOT + 1);
    localparam int TW    = $clog2(2 * PROG_CYC + 1);
    localparam int PW    = AW - PG_BITS;
    localparam logic [DW-1:0] CNT_LIM = DW'(NSLOT);

    seq_state_e    state;
    logic          blk;
    logic [PW-1:0] page;
    logic [CW-1:0] remain;
    logic [TW-1:0] tmr;
    logic          start_al;
    logic          last_d7;
    logic          ovf;
    logic          abt;

    logic [7:0] code;
    logic       same_blk;
    logic       same_page;
    logic       hit_unl_a;
    logic       hit_unl_b;
    logic       load_ok;

    always_comb begin
        code      = wr_data[7:0];
        same_blk  = (wr_addr[AW-1] == blk);
        same_page = (wr_addr[AW-1:PG_BITS] == page);
        hit_unl_a = (code == CMD_UNLOCK_A) && (wr_addr == AW'(UNLOCK_ADDR_A));
        hit_unl_b = (code == CMD_UNLOCK_B) && (wr_addr == AW'(UNLOCK_ADDR_B));
        load_ok   = ((state == S_FIRST) && same_blk) || ((state == S_LOAD) && same_page);
    end

    assign buf_we_o  = wr_en && load_ok;
    assign buf_clr_o = wr_en && (state == S_UNL2) && (code == CMD_SETUP);
    assign buf_idx_o = wr_addr[PG_BITS-1:0];
    assign commit_o  = (state == S_BUSY) && (tmr == TW'(1));
    assign state_o   = state;
    assign blk_o     = blk;
    assign page_o    = page;
    assign d7_inv_o  = ~last_d7;
    assign ovf_o     = ovf;
    assign abt_o     = abt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_READ;
            blk      <= 1'b0;
            page     <= '0;
            remain   <= '0;
            tmr      <= '0;
            start_al <= 1'b0;
            last_d7  <= 1'b0;
            ovf      <= 1'b0;
            abt      <= 1'b0;
        end else begin
            case (state)
                S_READ: begin
                    if (wr_en && hit_unl_a) begin
                        state <= S_UNL1;
                    end
                end
                S_UNL1: begin
                    if (wr_en) begin
                        state <= hit_unl_b ? S_UNL2 : S_READ;
                    end
                end
                S_UNL2: begin
                    if (wr_en) begin
                        if (code == CMD_SETUP) begin
                            state   <= S_COUNT;
                            blk     <= wr_addr[AW-1];
                            ovf     <= 1'b0;
                            abt     <= 1'b0;
                            last_d7 <= 1'b0;
                        end else begin
                            state <= S_READ;
                        end
                    end
                end
                S_COUNT: begin
                    if (wr_en) begin
                        if (!same_blk) begin
                            state <= S_ABORT;
                            abt   <= 1'b1;
                        end else if (wr_data >= CNT_LIM) begin
                            state <= S_ABORT;
                            ovf   <= 1'b1;
                        end else begin
                            remain <= wr_data[CW-1:0] + CW'(1);
                            state  <= S_FIRST;
                        end
                    end
                end
                S_FIRST, S_LOAD: begin
                    if (wr_en) begin
                        if (!load_ok) begin
                            state <= S_ABORT;
                            abt   <= 1'b1;
                        end else begin
                            if (state == S_FIRST) begin
                                page     <= wr_addr[AW-1:PG_BITS];
                                start_al <= (wr_addr[PG_BITS-1:0] == '0);
                            end
                            last_d7 <= wr_data[7];
                            remain  <= remain - CW'(1);
                            state   <= (remain == CW'(1)) ? S_CONFIRM : S_LOAD;
                        end
                    end
                end
                S_CONFIRM: begin
                    if (wr_en) begin
                        if (same_blk && (code == CMD_CONFIRM)) begin
                            state <= S_BUSY;
                            tmr   <= start_al ? TW'(PROG_CYC) : TW'(2 * PROG_CYC);
                        end else begin
                            state <= S_ABORT;
                            abt   <= 1'b1;
                        end
                    end
                end
                S_BUSY: begin
                    tmr <= tmr - TW'(1);
                    if (tmr == TW'(1)) begin
                        state <= S_READ;
                    end else if (wr_en && (code == CMD_SUSPEND)) begin
                        state <= S_SUSP;
                    end
                end
                S_SUSP: begin
                    if (wr_en && (code == CMD_RESUME)) begin
                        state <= S_BUSY;
                    end
                end
                S_ABORT: begin
                    if (wr_en && (code == CMD_RESET)) begin
                        state <= S_READ;
                        ovf   <= 1'b0;
                        abt   <= 1'b0;
                    end
                end
                default: state <= S_READ;
            endcase
        end
    end

endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
    import fbp_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 16,
    parameter int PG_BITS  = 5,
    parameter int PROG_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          err
);

    localparam int PW    = AW - PG_BITS;
    localparam int NSLOT = 1 << PG_BITS;

    seq_state_e              state;
    logic                    blk;
    logic [PW-1:0]           page;
    logic                    buf_clr;
    logic                    buf_we;
    logic [PG_BITS-1:0]      buf_idx;
    logic                    commit;
    logic                    d7_inv;
    logic                    ovf;
    logic                    abt;
    logic [NSLOT-1:0]        slot_valid;
    logic [NSLOT-1:0][DW-1:0] slot_data;
    logic [DW-1:0]           arr_rd;
    logic                    show_status;
    logic [DW-1:0]           status_word;

    fbp_seq_fsm #(
        .AW(AW), .DW(DW), .PG_BITS(PG_BITS), .PROG_CYC(PROG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .state_o   (state),
        .blk_o     (blk),
        .page_o    (page),
        .buf_clr_o (buf_clr),
        .buf_we_o  (buf_we),
        .buf_idx_o (buf_idx),
        .commit_o  (commit),
        .d7_inv_o  (d7_inv),
        .ovf_o     (ovf),
        .abt_o     (abt)
    );

    fbp_prog_buf #(
        .DW(DW), .PG_BITS(PG_BITS)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (buf_clr),
        .we_i    (buf_we),
        .idx_i   (buf_idx),
        .wdata_i (wr_data),
        .valid_o (slot_valid),
        .data_o  (slot_data)
    );

    fbp_array #(
        .AW(AW), .DW(DW), .PG_BITS(PG_BITS)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .page_i    (page),
        .valid_i   (slot_valid),
        .data_i    (slot_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (arr_rd)
    );

    fbp_status #(
        .DW(DW)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state),
        .blk_i     (blk),
        .rd_en_i   (rd_en),
        .rd_bank_i (rd_addr[AW-1]),
        .d7_inv_i  (d7_inv),
        .ovf_i     (ovf),
        .abt_i     (abt),
        .show_o    (show_status),
        .word_o    (status_word)
    );

    assign busy    = (state == S_BUSY);
    assign err     = (state == S_ABORT);
    assign rd_data = show_status ? status_word : arr_rd;

endmodule

// File: rtl/flash_bufprog_seq_chk.sv
module flash_bufprog_seq_chk
    import fbp_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 16,
    parameter int PROG_CYC = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [7:0]    wr_code,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          busy,
    input logic          err,
    input logic          show_status,
    input logic          commit
);

    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 16'd1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wr_en) && (($past(wr_code) == CMD_CONFIRM) || ($past(wr_code) == CMD_RESUME)))); // R2

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(rd_addr) && !show_status && !$past(show_status))
        |-> ((rd_data & ~$past(rd_data)) == '0)); // R3

    AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(wr_en)); // R6

    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy); // R7

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_run <= 16'(2 * PROG_CYC)); // R7

    AST_ERR_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> ($past(wr_en) && ($past(wr_code) == CMD_RESET))); // R10

endmodule

bind flash_bufprog_seq flash_bufprog_seq_chk #(
    .AW(AW), .DW(DW), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_code     (wr_data[7:0]),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .busy        (busy),
    .err         (err),
    .show_status (show_status),
    .commit      (commit)
);

// File: tb/flash_bufprog_seq_tb.sv
module flash_bufprog_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int DW         = 16;
    localparam int PROG       = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          err;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    logic [15:0] model [0:2047];

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_bufprog_seq #(.AW(AW), .DW(DW), .PG_BITS(5), .PROG_CYC(PROG)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .err(err)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] adr(input int bank, input int pg, input int off);
        return AW'((bank << 10) | (pg << 5) | off);
    endfunction

    function automatic logic [15:0] dfun(input int seed, input int i);
        return 16'(seed * 16'h3A5B) ^ 16'(i * 16'h1C3D) ^ 16'hC3A5;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(AW'('h555), 16'h00AA);
        wr(AW'('h2AA), 16'h0055);
    endtask

    task automatic load(input int bank, input int pg, input int st, input int n, input int seed,
                        output logic [15:0] last);
        unlock();
        wr(adr(bank, 7, 3), 16'h0025);
        wr(adr(bank, 0, 0), 16'(n));
        last = '0;
        for (int i = 0; i <= n; i++) begin
            last = dfun(seed, i);
            wr(adr(bank, pg, (st + i) % 32), last);
        end
    endtask

    task automatic apply(input int bank, input int pg, input int st, input int n, input int seed);
        for (int i = 0; i <= n; i++) begin
            model[adr(bank, pg, (st + i) % 32)] &= dfun(seed, i);
        end
    endtask

    task automatic confirm(input int bank);
        busy_cnt = 0;
        wr(adr(bank, 1, 1), 16'h0029);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic verify_page(input int bank, input int pg, input string req);
        for (int off = 0; off < 32; off++) begin
            rd_addr = adr(bank, pg, off);
            #1;
            chk(rd_data == model[rd_addr], req, rd_data, model[rd_addr]);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_sim();
    end

    initial begin
        logic [15:0] last;
        logic        b6a;
        for (int i = 0; i < 2048; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: erased array, idle outputs
        chk(!busy && !err, "R1", {busy, err}, 0);
        rd_addr = '0; #1;
        chk(rd_data == 16'hFFFF, "R1", rd_data, 16'hFFFF);
        rd_addr = AW'('h7FF); #1;
        chk(rd_data == 16'hFFFF, "R1", rd_data, 16'hFFFF);

        // R2/R7: sweep all counts, alternate banks and alignment
        for (int n = 0; n < 32; n++) begin
            int bank = n % 2;
            int st = (n % 3 == 0) ? 0 : (n * 7) % 32;
            load(bank, n, st, n, n + 1, last);
            confirm(bank);
            chk(busy, "R2", busy, 1);
            wait_idle();
            chk(busy_cnt == ((st == 0) ? PROG : 2 * PROG), "R7", busy_cnt, (st == 0) ? PROG : 2 * PROG);
            chk(!err, "R7", err, 0);
            apply(bank, n, st, n, n + 1);
            verify_page(bank, n, "R2");
        end

        // R3: second pass merges with AND
        for (int n = 0; n < 32; n++) begin
            int bank = n % 2;
            int st = (n % 3 == 0) ? 0 : (n * 7) % 32;
            load(bank, n, st, n, n + 100, last);
            confirm(bank);
            wait_idle();
            chk(busy_cnt == ((st == 0) ? PROG : 2 * PROG), "R7", busy_cnt, (st == 0) ? PROG : 2 * PROG);
            apply(bank, n, st, n, n + 100);
            verify_page(bank, n, "R3");
        end

        // R4: repeated address, last load wins, count decrements per load
        unlock();
        wr(adr(0, 9, 9), 16'h0025);
        wr(adr(0, 0, 0), 16'd2);
        wr(adr(0, 21, 4), 16'h00FF);
        wr(adr(0, 21, 4), 16'hF0F0);
        wr(adr(0, 21, 5), 16'h1234);
        confirm(0);
        chk(busy && !err, "R4", {busy, err}, 2'b10);
        wait_idle();
        model[adr(0, 21, 4)] &= 16'hF0F0;
        model[adr(0, 21, 5)] &= 16'h1234;
        verify_page(0, 21, "R4");

        // R5/R9/R10: count overflow
        unlock();
        wr(adr(1, 0, 9), 16'h0025);
        wr(adr(1, 0, 0), 16'd32);
        chk(err && !busy, "R5", {err, busy}, 2'b10);
        rd_addr = adr(1, 4, 0); #1;
        chk((rd_data & 16'hFFBF) == 16'h00A0, "R5", rd_data, 16'h00A0);
        rd_addr = adr(0, 4, 0); #1;
        chk(rd_data == model[rd_addr], "R9", rd_data, model[rd_addr]);
        wr(adr(0, 0, 0), 16'h00F0);
        chk(!err, "R10", err, 0);
        rd_addr = adr(1, 4, 0); #1;
        chk(rd_data == model[rd_addr], "R10", rd_data, model[rd_addr]);

        // R6: load outside page of first load
        unlock();
        wr(adr(0, 3, 3), 16'h0025);
        wr(adr(0, 0, 0), 16'd3);
        wr(adr(0, 24, 0), 16'h1280);
        wr(adr(0, 25, 0), 16'h0000);
        chk(err, "R6", err, 1);
        rd_addr = adr(0, 24, 0); #1;
        chk((rd_data & 16'hFFBF) == 16'h0002, "R6", rd_data, 16'h0002);
        wr(adr(0, 0, 0), 16'h00F0);
        chk(!err, "R10", err, 0);
        verify_page(0, 24, "R6");

        // R6/R9: wrong confirm code
        unlock();
        wr(adr(1, 3, 3), 16'h0025);
        wr(adr(1, 0, 0), 16'd0);
        wr(adr(1, 26, 3), 16'h0011);
        wr(adr(1, 0, 0), 16'h0028);
        chk(err, "R6", err, 1);
        rd_addr = adr(1, 26, 3); #1;
        chk((rd_data & 16'hFFBF) == 16'h0082, "R9", rd_data, 16'h0082);
        rd_addr = adr(0, 26, 3); #1;
        chk(rd_data == model[rd_addr], "R9", rd_data, model[rd_addr]);
        wr(adr(1, 0, 0), 16'h00F0);
        verify_page(1, 26, "R6");

        // R6: count written to the other bank
        unlock();
        wr(adr(0, 3, 3), 16'h0025);
        wr(adr(1, 0, 0), 16'd1);
        chk(err, "R6", err, 1);
        wr(adr(0, 0, 0), 16'h00F0);
        chk(!err && !busy, "R10", {err, busy}, 0);

        // R8: status while busy
        load(1, 3, 0, 4, 77, last);
        confirm(1);
        rd_addr = adr(1, 3, 0); #1;
        chk((rd_data & 16'hFFBF) == {8'h00, ~last[7], 7'h00}, "R8", rd_data, {8'h00, ~last[7], 7'h00});
        @(negedge clk);
        rd_en = 1'b1; #1;
        b6a = rd_data[6];
        @(negedge clk);
        rd_en = 1'b0; #1;
        chk(rd_data[6] == ~b6a, "R8", rd_data[6], ~b6a);
        rd_addr = adr(0, 3, 0); #1;
        chk(rd_data == model[rd_addr], "R8", rd_data, model[rd_addr]);
        wait_idle();
        apply(1, 3, 0, 4, 77);
        verify_page(1, 3, "R8");

        // R11: suspend and resume
        load(0, 22, 0, 2, 55, last);
        confirm(0);
        @(negedge clk);
        wr(adr(0, 5, 5), 16'h00B0);
        chk(!busy && !err, "R11", {busy, err}, 0);
        rd_addr = adr(0, 22, 0); #1;
        chk(rd_data == model[rd_addr], "R11", rd_data, model[rd_addr]);
        repeat (6) @(negedge clk);
        chk(!busy, "R11", busy, 0);
        wr(adr(0, 5, 5), 16'h0030);
        chk(busy, "R11", busy, 1);
        wait_idle();
        chk(busy_cnt == PROG, "R11", busy_cnt, PROG);
        apply(0, 22, 0, 2, 55);
        verify_page(0, 22, "R11");

        // R12: broken unlock (wrong data, then wrong address)
        wr(AW'('h555), 16'h00AA);
        wr(AW'('h2AA), 16'h0054);
        wr(adr(0, 2, 2), 16'h0025);
        wr(adr(0, 0, 0), 16'd0);
        wr(adr(0, 30, 0), 16'h0000);
        wr(adr(0, 0, 0), 16'h0029);
        chk(!busy && !err, "R12", {busy, err}, 0);
        wr(AW'('h554), 16'h00AA);
        wr(AW'('h2AA), 16'h0055);
        wr(adr(0, 2, 2), 16'h0025);
        wr(adr(0, 0, 0), 16'd0);
        wr(adr(0, 30, 1), 16'h0000);
        wr(adr(0, 0, 0), 16'h0029);
        chk(!busy && !err, "R12", {busy, err}, 0);
        verify_page(0, 30, "R12");

        finish_sim();
    end

endmodule